// File: doc/BRIEF.md
# AGC Pulse-Width Modulator Pair

This block drives two external gain-control amplifiers, one for the tuner and one for the IF stage. Each amplifier sits behind a single RC low-pass network. Each output is a pulse-width modulated square wave whose high time per period encodes an unsigned level of `DUTY_W` bits. The tuner channel always follows the level produced by the receiver's AGC loop. The IF channel follows either its own AGC loop level or a fixed level that the host has written, depending on a source-select bit.

Levels are not followed continuously. A 10-bit counter counts symbol strobes. Every 1024th strobe copies the selected levels into a shadow register per channel. The level inputs and the source select are sampled only on that strobe. A shadowed level becomes the active duty at the next PWM period boundary, so a period is never cut short or stretched by an update. The period is made of `2^DUTY_W - 1` slots. A slot advances once every `TICK_DIV` crystal clocks, which keeps the PWM frequency at or below one sixteenth of the crystal clock.

Top module: `agc_pwm_pair`

## Requirements
- R1: While `rst_n` is low, and after reset until the first level has been shadowed and a period boundary has passed, both outputs are low (active duty 0).
- R2: With active duty D, an output is high during the first D slots of each period and low during the remaining slots, so a period begins with its high phase.
- R3: An active duty of 0 holds the output low for the whole period.
- R4: An active duty of all ones (`2^DUTY_W - 1`) holds the output high for the whole period.
- R5: A period lasts `(2^DUTY_W - 1) * TICK_DIV` crystal clocks and a slot advances every `TICK_DIV` clocks; with the defaults (8 bits, divide by 1) this is 255 clocks, and two rising edges of an output are never closer than 16 clocks.
- R6: A shadow register is loaded only on the clock edge that carries the 1024th symbol strobe since the last load (the 10-bit symbol count wraps from 1023 to 0); level values present on any other edge are ignored.
- R7: A shadowed level becomes active on the clock edge that ends a period, and it is then in force from the first slot of the next period. A load that happens on that same edge waits one more period.
- R8: The tuner output always takes its level from `tun_loop_lvl`.
- R9: The IF output takes `if_loop_lvl` when `if_src_sel` is 0 and `if_host_lvl` when it is 1. The select is sampled on the same symbol-wrap edge as the levels and has no effect at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_stb | input | 1 | One-cycle symbol strobe |
| tun_loop_lvl | input | DUTY_W | Tuner gain level from the AGC loop |
| if_loop_lvl | input | DUTY_W | IF gain level from the AGC loop |
| if_host_lvl | input | DUTY_W | IF gain level written by the host |
| if_src_sel | input | 1 | IF source: 0 loop level, 1 host level |
| pwm_tun | output | 1 | Tuner gain PWM output |
| pwm_if | output | 1 | IF gain PWM output |

## Verification
The bench drives refresh windows with strobes on every cycle and with strobes spaced two and three cycles apart. This confirms that the refresh follows the 1024th strobe and not elapsed time. Between wraps the level inputs and the select carry changing values that must never appear at the outputs, which separates a wrap-only load from a load on any strobe. The levels used include 0, all ones, 1, 254 and mid values, and the IF channel alternates between loop and host sources, which separates the constant-low, constant-high and proportional shapes and shows that only the IF channel switches source. Each period is compared slot by slot against the expected shape, so an update that lands mid-period or a period of the wrong length shows up as a misplaced high slot.

// File: rtl/agc_pwm_pkg.sv
// Shared constants and types for the AGC PWM pair.
package agc_pwm_pkg;
    localparam int SYM_CNT_W = 10;
    localparam int NUM_CH    = 2;
    localparam int CH_TUN    = 0;
    localparam int CH_IF     = 1;

    typedef enum logic {
        IF_SRC_LOOP = 1'b0,
        IF_SRC_HOST = 1'b1
    } if_src_e;
endpackage

// File: rtl/agc_sym_counter.sv
// Symbol refresh counter.
// Counts symbol strobes modulo 2^CNT_W and flags the strobe that wraps
// the count. Assumes sym_stb is a one-cycle pulse per symbol.
module agc_sym_counter #(
    parameter int CNT_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_stb,
    output logic wrap
);
    logic [CNT_W-1:0] cnt_q;

    // Advance the symbol count on every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (sym_stb) cnt_q <= cnt_q + 1'b1;
    end

    assign wrap = sym_stb && (cnt_q == {CNT_W{1'b1}});
endmodule

// File: rtl/agc_period_timer.sv
// PWM slot timer shared by both channels.
// Slot index runs 0 .. 2^SLOT_W-2 and advances once every TICK_DIV clocks.
// period_end marks the clock edge on which the last slot finishes.
// Assumes TICK_DIV >= 1 and (2^SLOT_W-1)*TICK_DIV >= 16.
module agc_period_timer #(
    parameter int SLOT_W   = 8,
    parameter int TICK_DIV = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot,
    output logic              period_end
);
    localparam logic [SLOT_W-1:0] SLOT_LAST = {{(SLOT_W-1){1'b1}}, 1'b0};

    logic tick;

    generate
        if (TICK_DIV == 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DIV_W = $clog2(TICK_DIV);
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
            logic [DIV_W-1:0] pre_q;

            // Prescaler: one tick per TICK_DIV clocks.
            always_ff @(posedge clk) begin
                if (!rst_n)                pre_q <= '0;
                else if (pre_q == DIV_LAST) pre_q <= '0;
                else                        pre_q <= pre_q + 1'b1;
            end

            assign tick = (pre_q == DIV_LAST);
        end
    endgenerate

    logic [SLOT_W-1:0] slot_q;

    // Slot index, wrapping after the last slot of a period.
    always_ff @(posedge clk) begin
        if (!rst_n)                   slot_q <= '0;
        else if (tick && slot_q == SLOT_LAST) slot_q <= '0;
        else if (tick)                slot_q <= slot_q + 1'b1;
    end

    assign slot       = slot_q;
    assign period_end = tick && (slot_q == SLOT_LAST);
endmodule

// File: rtl/agc_pwm_channel.sv
// One PWM channel with a shadow and an active duty register.
// The shadow takes the level on load; the active duty takes the shadow
// on period_end, so the duty only changes between periods. The output is
// high while the slot index is below the active duty.
module agc_pwm_channel #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              period_end,
    input  logic [DUTY_W-1:0] level,
    input  logic [DUTY_W-1:0] slot,
    output logic [DUTY_W-1:0] shadow,
    output logic [DUTY_W-1:0] active,
    output logic              pwm
);
    logic [DUTY_W-1:0] shadow_q;
    logic [DUTY_W-1:0] active_q;

    // Capture the level on a symbol-count wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    shadow_q <= '0;
        else if (load) shadow_q <= level;
    end

    // Promote the shadow to the active duty at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n)          active_q <= '0;
        else if (period_end) active_q <= shadow_q;
    end

    assign shadow = shadow_q;
    assign active = active_q;
    assign pwm    = (active_q > slot);
endmodule

// File: rtl/agc_pwm_pair.sv
// AGC PWM pair: tuner and IF gain outputs.
// The tuner always follows its loop level; the IF channel follows its loop
// level or the host level per if_src_sel. Levels and select are sampled
// only when the symbol counter wraps. Assumes synchronous active-low reset.
module agc_pwm_pair
    import agc_pwm_pkg::*;
#(
    parameter int DUTY_W   = 8,
    parameter int TICK_DIV = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_stb,
    input  logic [DUTY_W-1:0] tun_loop_lvl,
    input  logic [DUTY_W-1:0] if_loop_lvl,
    input  logic [DUTY_W-1:0] if_host_lvl,
    input  logic              if_src_sel,
    output logic              pwm_tun,
    output logic              pwm_if
);
    logic              sym_wrap;
    logic              period_end;
    logic [DUTY_W-1:0] slot;
    logic [DUTY_W-1:0] src_lvl    [NUM_CH];
    logic [DUTY_W-1:0] shadow_lvl [NUM_CH];
    logic [DUTY_W-1:0] active_lvl [NUM_CH];
    logic [NUM_CH-1:0] pwm_bus;
    if_src_e           if_src;

    agc_sym_counter #(.CNT_W(SYM_CNT_W)) u_sym (
        .clk     (clk),
        .rst_n   (rst_n),
        .sym_stb (sym_stb),
        .wrap    (sym_wrap)
    );

    agc_period_timer #(.SLOT_W(DUTY_W), .TICK_DIV(TICK_DIV)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot       (slot),
        .period_end (period_end)
    );

    assign if_src = if_src_e'(if_src_sel);

    // Pick each channel's level source.
    always_comb begin
        src_lvl[CH_TUN] = tun_loop_lvl;
        src_lvl[CH_IF]  = (if_src == IF_SRC_HOST) ? if_host_lvl : if_loop_lvl;
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            agc_pwm_channel #(.DUTY_W(DUTY_W)) u_ch (
                .clk        (clk),
                .rst_n      (rst_n),
                .load       (sym_wrap),
                .period_end (period_end),
                .level      (src_lvl[c]),
                .slot       (slot),
                .shadow     (shadow_lvl[c]),
                .active     (active_lvl[c]),
                .pwm        (pwm_bus[c])
            );
        end
    endgenerate

    assign pwm_tun = pwm_bus[CH_TUN];
    assign pwm_if  = pwm_bus[CH_IF];
endmodule

// File: rtl/agc_pwm_pair_chk.sv
// Property checker for agc_pwm_pair, attached by bind below.
// Keeps its own symbol count and rising-edge spacing counter.
module agc_pwm_pair_chk #(
    parameter int DUTY_W  = 8,
    parameter int MIN_GAP = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sym_stb,
    input logic [DUTY_W-1:0] slot,
    input logic [DUTY_W-1:0] shadow_tun,
    input logic [DUTY_W-1:0] active_tun,
    input logic [DUTY_W-1:0] active_if,
    input logic              pwm_tun,
    input logic              pwm_if
);
    logic [9:0]  sym_seen_q;
    logic [15:0] gap_q;
    logic        prev_tun_q;

    // Independent count of symbol strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)       sym_seen_q <= '0;
        else if (sym_stb) sym_seen_q <= sym_seen_q + 1'b1;
    end

    // Clocks since the last rising edge of the tuner output, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q      <= '0;
            prev_tun_q <= 1'b0;
        end else begin
            prev_tun_q <= pwm_tun;
            if (pwm_tun && !prev_tun_q) gap_q <= '0;
            else if (gap_q != 16'hFFFF) gap_q <= gap_q + 1'b1;
        end
    end

    // R6
    shadow_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(shadow_tun) |-> ($past(sym_stb) && $past(sym_seen_q) == 10'h3FF));

    // R7
    active_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(active_tun) || !$stable(active_if)) |-> slot == '0);

    // R2
    rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pwm_tun) || $rose(pwm_if)) |-> slot == '0);

    // R3
    zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_tun == '0) |-> !pwm_tun);

    // R4
    full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_if == {DUTY_W{1'b1}}) |-> pwm_if);

    // R5
    rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_tun && !prev_tun_q) |-> gap_q >= 16'(MIN_GAP - 1));
endmodule

bind agc_pwm_pair agc_pwm_pair_chk #(.DUTY_W(DUTY_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_stb    (sym_stb),
    .slot       (slot),
    .shadow_tun (shadow_lvl[0]),
    .active_tun (active_lvl[0]),
    .active_if  (active_lvl[1]),
    .pwm_tun    (pwm_tun),
    .pwm_if     (pwm_if)
);

// File: tb/tb_agc_pwm_pair.sv
// Scoreboard bench: the driver pushes the levels it presents on each
// symbol wrap; the monitor pops the one in force for each period and
// compares every slot of both outputs.
module tb_agc_pwm_pair;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int NSLOT      = (1 << W) - 1;   // R5: period in clocks at divide 1

    typedef struct {
        int         edge_k;
        logic [7:0] tun;
        logic [7:0] ifv;
        bit         host;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sym_stb = 1'b0;
    logic [W-1:0] tun_loop_lvl = '0;
    logic [W-1:0] if_loop_lvl = '0;
    logic [W-1:0] if_host_lvl = '0;
    logic         if_src_sel = 1'b0;
    logic         pwm_tun;
    logic         pwm_if;

    int  checks = 0;
    int  fails  = 0;
    int  cyc    = 0;
    int  sym_seen = 0;
    bit  done   = 1'b0;
    exp_t q[$];

    agc_pwm_pair #(.DUTY_W(W), .TICK_DIV(1)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sym_stb      (sym_stb),
        .tun_loop_lvl (tun_loop_lvl),
        .if_loop_lvl  (if_loop_lvl),
        .if_host_lvl  (if_host_lvl),
        .if_src_sel   (if_src_sel),
        .pwm_tun      (pwm_tun),
        .pwm_if       (pwm_if)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Posedges since reset release.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Driver: one refresh window. Junk is driven except on the wrap edge (R6, R9).
    task automatic window(input logic [7:0] tun, input logic [7:0] lp,
                          input logic [7:0] host, input bit sel, input int gap);
        int ph = 0;
        forever begin
            @(negedge clk);
            sym_stb = (ph == 0);
            ph = (ph == gap) ? 0 : ph + 1;
            if (sym_stb && sym_seen == 1023) begin
                tun_loop_lvl = tun;
                if_loop_lvl  = lp;
                if_host_lvl  = host;
                if_src_sel   = sel;
                q.push_back('{edge_k: cyc, tun: tun, ifv: (sel ? host : lp), host: sel});
                sym_seen = 0;
                break;
            end
            if (sym_stb) sym_seen++;
            tun_loop_lvl = 8'(sym_seen * 7 + 3);
            if_loop_lvl  = 8'(sym_seen * 13 + 91);
            if_host_lvl  = 8'(sym_seen * 5 + 200);
            if_src_sel   = sym_seen[0];
        end
        @(negedge clk);
        sym_stb      = 1'b0;
        tun_loop_lvl = ~tun;
        if_loop_lvl  = ~lp;
        if_host_lvl  = ~host;
        if_src_sel   = ~sel;
    endtask

    function automatic string tag_for(input logic [7:0] d, input bit loaded);
        if (!loaded)        return "R1";
        if (d == 8'd0)      return "R3";
        if (d == 8'hFF)     return "R4";
        return "R2";
    endfunction

    // Monitor state
    logic [7:0] exp_t_d = 8'd0, exp_i_d = 8'd0;
    bit         exp_host = 1'b0, loaded = 1'b0;
    int         hi_t = 0, hi_i = 0;
    bit         bad_t = 1'b0, bad_i = 1'b0;
    int         idx = 0, per = 0;
    exp_t       it;

    // Monitor: per-period slot-by-slot comparison (R2..R9).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            idx = cyc % NSLOT;
            per = cyc / NSLOT;
            if (idx == 0) begin
                // R7: level loaded on edge <= period start - 2 is in force
                while (q.size() > 0 && q[0].edge_k <= NSLOT * per - 2) begin
                    it = q.pop_front();
                    exp_t_d = it.tun; exp_i_d = it.ifv; exp_host = it.host; loaded = 1'b1;
                end
                hi_t = 0; hi_i = 0; bad_t = 1'b0; bad_i = 1'b0;
            end
            if (pwm_tun) hi_t++;
            if (pwm_if)  hi_i++;
            if (pwm_tun !== (idx < exp_t_d)) bad_t = 1'b1;
            if (pwm_if  !== (idx < exp_i_d)) bad_i = 1'b1;
            if (idx == NSLOT - 1) begin
                checks++;
                if (bad_t) begin
                    fails++;
                    $display("FAIL %s R8 R5 R6 R7 tuner period %0d: high slots %0d expected %0d",
                             tag_for(exp_t_d, loaded), per, hi_t, exp_t_d);
                end
                checks++;
                if (bad_i) begin
                    fails++;
                    $display("FAIL %s R9 R5 R6 R7 IF(%s) period %0d: high slots %0d expected %0d",
                             tag_for(exp_i_d, loaded), exp_host ? "host" : "loop",
                             per, hi_i, exp_i_d);
                end
            end
        end
    end

    initial begin
        // R1: outputs low in reset while inputs are active
        sym_stb = 1'b1; tun_loop_lvl = 8'hFF; if_loop_lvl = 8'hFF; if_host_lvl = 8'hFF;
        repeat (3) @(negedge clk);
        checks++;
        if (pwm_tun !== 1'b0 || pwm_if !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs %b%b expected 00", pwm_tun, pwm_if);
        end
        sym_stb = 1'b0; tun_loop_lvl = '0; if_loop_lvl = '0; if_host_lvl = '0;
        @(negedge clk);
        rst_n = 1'b1;
        window(8'h80, 8'h40, 8'h10, 1'b0, 0);   // mid values, IF from loop
        window(8'h00, 8'hFF, 8'h22, 1'b0, 0);   // R3 tuner, R4 IF
        window(8'hFF, 8'h33, 8'hCC, 1'b1, 1);   // R4 tuner, R9 host, spaced strobes
        window(8'h01, 8'hFE, 8'h00, 1'b1, 0);   // duty 1, host 0
        window(8'h5A, 8'hA5, 8'h77, 1'b0, 2);   // R9 back to loop
        window(8'h9C, 8'h12, 8'hFE, 1'b1, 0);   // host 254
        repeat (3 * NSLOT + 5) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule